// File: doc/BRIEF.md
# Multiprocessor-Mode UART Receiver

This block receives asynchronous serial characters for a node that shares one line with several other nodes under a single master. It oversamples the line on a 16x tick from an external baud generator. It accepts frames with 5 to 8 data bits. Each frame carries one frame-type bit after the last data bit. A type bit of 1 marks an address frame and a type bit of 0 marks a data frame. In the 9-bit setting there are eight data bits, and the ninth bit is the type bit. In the shorter settings the type bit occupies the first stop slot, so every frame has the same shape: start, data, type, stop.

When multiprocessor mode is enabled, the receiver filters in hardware. Address frames are delivered and flagged. Data frames are dropped without touching the holding register or the receive-complete flag. Software compares the received address itself. When the address matches, software clears the mode bit to accept the data frames that follow, and sets it again at the end of the message.

The mode bit sits in a configuration register together with a transmit-complete flag owned by a neighbouring transmitter. A configuration write never disturbs that flag.

Top module: `mpUartRx`

## Requirements
- R1: After reset the receiver is idle, `rxReady`, `rxOverrun`, `rxFrameErr`, `rxType` and `txDone` are 0, `mpMode` is 0, and `charSel` is 3 (8 data bits).
- R2: A frame consists of a low start bit, then N data bits least significant bit first, then the type bit, then a high stop bit. N is `charSel`+5 for codes 0 to 3, and N is 8 for codes 4 to 7 (the 9-bit setting). Each bit is sampled at mid-bit (the 8th of 16 ticks). Data bits above N read as 0.
- R3: A falling edge whose mid-start sample reads high is treated as a glitch. No frame is started and no flag changes.
- R4: With `mpMode`=1, a frame with type bit 0 leaves `rxReady`, `rxData`, `rxType`, `rxFrameErr` and `rxOverrun` unchanged.
- R5: With `mpMode`=1, a frame with type bit 1 is loaded and sets `rxReady`.
- R6: With `mpMode`=0, every frame is loaded and flagged, whatever its type bit, and `rxType` returns that bit.
- R7: If the stop sample reads 0, `rxFrameErr`=1 is stored with the delivered frame. A good stop bit stores 0.
- R8: If a deliverable frame completes while `rxReady`=1 and no read occurs in that cycle, `rxOverrun` is set and the unread frame stays in the register.
- R9: A one-cycle `rdStrobe` clears `rxReady` and `rxOverrun` on the next cycle.
- R10: A `cfgWr` loads `mpMode` and `charSel` and leaves `txDone` unchanged. `txDone` is set only by `txDoneSet` and cleared only by `txDoneClr`.
- R11: In the 5-bit setting, the type bit is taken from the first stop slot, and the frame completes after a second stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sampleTick | input | 1 | 16x oversampling strobe |
| rxLine | input | 1 | Serial input, idle high |
| cfgWr | input | 1 | Configuration write strobe |
| cfgMpMode | input | 1 | Multiprocessor mode value to write |
| cfgCharSel | input | 3 | Character size code to write |
| txDoneSet | input | 1 | Transmitter sets transmit-complete |
| txDoneClr | input | 1 | Explicit clear of transmit-complete |
| rdStrobe | input | 1 | Data register read acknowledge |
| mpMode | output | 1 | Current multiprocessor mode |
| charSel | output | 3 | Current character size code |
| txDone | output | 1 | Transmit-complete flag |
| rxData | output | 8 | Received data bits |
| rxType | output | 1 | Stored frame-type bit |
| rxFrameErr | output | 1 | Stored framing error |
| rxReady | output | 1 | Receive-complete flag |
| rxOverrun | output | 1 | Overrun flag |

## Verification
The checker watches several properties on every cycle. Any rise of the receive-complete flag must carry type bit 1 when the mode was on. A read must clear both flags. An overrun must leave the held frame untouched. A configuration write must load the mode bit while the transmit-complete flag stays put. Bit order, mid-bit sampling, glitch rejection, the per-size frame shapes and the stored framing error depend on whole serial waveforms. Only the bench's directed frames can show those.

// File: rtl/mpUartRxPkg.sv
package mpUartRxPkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int IDX_W  = 4;

  typedef struct packed {
    logic             clear;
    logic             capture;
    logic [IDX_W-1:0] bitIdx;
    logic             bitVal;
    logic             finish;
    logic             stopVal;
  } rxStrobe_t;

  function automatic logic [IDX_W-1:0] selToLen(input logic [SEL_W-1:0] sel);
    if (sel >= SEL_W'(4)) return IDX_W'(DATA_W);
    return IDX_W'(sel) + IDX_W'(5);
  endfunction
endpackage

// File: rtl/mpUartRxCfg.sv
module mpUartRxCfg
  import mpUartRxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgMpMode,
  input  logic [SEL_W-1:0] cfgCharSel,
  input  logic             txDoneSet,
  input  logic             txDoneClr,
  output logic             mpMode,
  output logic [SEL_W-1:0] charSel,
  output logic             txDone
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mpMode  <= 1'b0;
      charSel <= SEL_W'(3);
      txDone  <= 1'b0;
    end else begin
      if (cfgWr) begin
        mpMode  <= cfgMpMode;
        charSel <= cfgCharSel;
      end
      if (txDoneClr)      txDone <= 1'b0;
      else if (txDoneSet) txDone <= 1'b1;
    end
  end
endmodule

// File: rtl/mpUartRxCtrl.sv
module mpUartRxCtrl
  import mpUartRxPkg::*;
#(
  parameter int OSR = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxLine,
  input  logic [IDX_W-1:0] dataLen,
  output rxStrobe_t        strb
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS, ST_STOP} rxState_t;

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             rxMeta, rxSync, prevLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      prevLine <= 1'b1;
    end else if (sampleTick) begin
      prevLine <= rxSync;
      case (state)
        ST_IDLE: begin
          if (prevLine && !rxSync) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tickCnt == MID) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxSync ? ST_IDLE : ST_BITS;
          end else tickCnt <= tickCnt + 1'b1;
        end
        ST_BITS: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            bitIdx  <= bitIdx + 1'b1;
            if (bitIdx == dataLen) state <= ST_STOP;
          end else tickCnt <= tickCnt + 1'b1;
        end
        ST_STOP: begin
          if (tickCnt == LAST) state <= ST_IDLE;
          else tickCnt <= tickCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clear   = sampleTick && state == ST_START && tickCnt == MID && !rxSync;
    strb.capture = sampleTick && state == ST_BITS && tickCnt == LAST;
    strb.bitIdx  = bitIdx;
    strb.bitVal  = rxSync;
    strb.finish  = sampleTick && state == ST_STOP && tickCnt == LAST;
    strb.stopVal = rxSync;
  end
endmodule

// File: rtl/mpUartRxData.sv
module mpUartRxData
  import mpUartRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [IDX_W-1:0]  dataLen,
  input  logic              mpMode,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxType,
  output logic              rxFrameErr,
  output logic              rxReady,
  output logic              rxOverrun
);
  logic [DATA_W-1:0] shData;
  logic              shType;
  logic              deliver;

  assign deliver = strb.finish && (!mpMode || shType);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shData <= '0;
      shType <= 1'b0;
    end else begin
      if (strb.clear) begin
        shData <= '0;
        shType <= 1'b0;
      end
      if (strb.capture) begin
        if (strb.bitIdx < dataLen) shData[strb.bitIdx[2:0]] <= strb.bitVal;
        else                       shType <= strb.bitVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxType     <= 1'b0;
      rxFrameErr <= 1'b0;
      rxReady    <= 1'b0;
      rxOverrun  <= 1'b0;
    end else begin
      if (rdStrobe) begin
        rxReady   <= 1'b0;
        rxOverrun <= 1'b0;
      end
      if (deliver) begin
        if (rxReady && !rdStrobe) rxOverrun <= 1'b1;
        else begin
          rxData     <= shData;
          rxType     <= shType;
          rxFrameErr <= !strb.stopVal;
          rxReady    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mpUartRx.sv
module mpUartRx
  import mpUartRxPkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic              cfgWr,
  input  logic              cfgMpMode,
  input  logic [SEL_W-1:0]  cfgCharSel,
  input  logic              txDoneSet,
  input  logic              txDoneClr,
  input  logic              rdStrobe,
  output logic              mpMode,
  output logic [SEL_W-1:0]  charSel,
  output logic              txDone,
  output logic [DATA_W-1:0] rxData,
  output logic              rxType,
  output logic              rxFrameErr,
  output logic              rxReady,
  output logic              rxOverrun
);
  rxStrobe_t        strb;
  logic [IDX_W-1:0] dataLen;

  assign dataLen = selToLen(charSel);

  mpUartRxCfg uCfg (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMpMode(cfgMpMode),
    .cfgCharSel(cfgCharSel), .txDoneSet(txDoneSet), .txDoneClr(txDoneClr),
    .mpMode(mpMode), .charSel(charSel), .txDone(txDone)
  );

  mpUartRxCtrl #(.OSR(OSR)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .dataLen(dataLen), .strb(strb)
  );

  mpUartRxData uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dataLen(dataLen), .mpMode(mpMode),
    .rdStrobe(rdStrobe), .rxData(rxData), .rxType(rxType),
    .rxFrameErr(rxFrameErr), .rxReady(rxReady), .rxOverrun(rxOverrun)
  );
endmodule

// File: rtl/mpUartRxChk.sv
module mpUartRxChk
  import mpUartRxPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rdStrobe,
  input logic              cfgWr,
  input logic              cfgMpMode,
  input logic              txDoneSet,
  input logic              txDoneClr,
  input logic              txDone,
  input logic              mpMode,
  input logic              rxReady,
  input logic              rxType,
  input logic [DATA_W-1:0] rxData,
  input logic              rxOverrun,
  input rxStrobe_t         strb
);
  AST_MP_DROPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> (!$past(mpMode) || rxType)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !strb.finish) |=> (!rxReady && !rxOverrun)); // R9

  AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> ($stable(rxData) && $stable(rxType))); // R8

  AST_TXDONE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!txDoneSet && !txDoneClr) |=> (txDone == $past(txDone))); // R10

  AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (mpMode == $past(cfgMpMode))); // R10
endmodule

bind mpUartRx mpUartRxChk uChk (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .cfgWr(cfgWr),
  .cfgMpMode(cfgMpMode), .txDoneSet(txDoneSet), .txDoneClr(txDoneClr),
  .txDone(txDone), .mpMode(mpMode), .rxReady(rxReady), .rxType(rxType),
  .rxData(rxData), .rxOverrun(rxOverrun), .strb(strb)
);

// File: tb/sim_mpUartRx.sv
`timescale 1ns/1ps
module sim_mpUartRx;
  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       cfgWr = 1'b0, cfgMpMode = 1'b0;
  logic [2:0] cfgCharSel = 3'd3;
  logic       txDoneSet = 1'b0, txDoneClr = 1'b0, rdStrobe = 1'b0;
  logic       mpMode, txDone, rxType, rxFrameErr, rxReady, rxOverrun;
  logic [2:0] charSel;
  logic [7:0] rxData;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  mpUartRx u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .cfgWr(cfgWr), .cfgMpMode(cfgMpMode), .cfgCharSel(cfgCharSel),
    .txDoneSet(txDoneSet), .txDoneClr(txDoneClr), .rdStrobe(rdStrobe),
    .mpMode(mpMode), .charSel(charSel), .txDone(txDone), .rxData(rxData),
    .rxType(rxType), .rxFrameErr(rxFrameErr), .rxReady(rxReady),
    .rxOverrun(rxOverrun)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    sampleTick = ~sampleTick;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input int nData, input logic [7:0] data,
                           input logic typ, input logic stopBit);
    rxLine = 1'b0; idle(BITCLK);
    for (int i = 0; i < nData; i++) begin
      rxLine = data[i]; idle(BITCLK);
    end
    rxLine = typ;     idle(BITCLK);
    rxLine = stopBit; idle(BITCLK);
    rxLine = 1'b1;    idle(2 * BITCLK);
  endtask

  task automatic readReg();
    rdStrobe = 1'b1; idle(1);
    rdStrobe = 1'b0; idle(1);
  endtask

  task automatic writeCfg(input logic mp, input logic [2:0] sel);
    cfgWr = 1'b1; cfgMpMode = mp; cfgCharSel = sel; idle(1);
    cfgWr = 1'b0; idle(1);
  endtask

  task automatic testReset();
    chk("R1 rxReady", 16'(rxReady), 16'h0);
    chk("R1 mpMode", 16'(mpMode), 16'h0);
    chk("R1 charSel", 16'(charSel), 16'h3);
    chk("R1 flags", 16'({rxOverrun, rxFrameErr, rxType, txDone}), 16'h0);
  endtask

  task automatic testPlainFrames();
    sendFrame(8, 8'hA5, 1'b0, 1'b1);
    chk("R6 ready on type0", 16'(rxReady), 16'h1);
    chk("R2 data lsb first", 16'(rxData), 16'hA5);
    chk("R6 type0", 16'(rxType), 16'h0);
    chk("R7 good stop", 16'(rxFrameErr), 16'h0);
    readReg();
    chk("R9 read clears ready", 16'(rxReady), 16'h0);
    sendFrame(8, 8'h3C, 1'b1, 1'b1);
    chk("R6 type1 data", 16'({rxReady, rxType, rxData}), 16'h33C);
    readReg();
  endtask

  task automatic testSizes();
    writeCfg(1'b0, 3'd0);
    chk("R10 charSel load", 16'(charSel), 16'h0);
    sendFrame(5, 8'h15, 1'b1, 1'b1);
    chk("R11 five-bit frame", 16'({rxReady, rxType, rxData}), 16'h315);
    readReg();
    writeCfg(1'b0, 3'd2);
    sendFrame(7, 8'h5A, 1'b0, 1'b1);
    chk("R2 seven-bit upper zero", 16'({rxType, rxData}), 16'h05A);
    readReg();
    writeCfg(1'b0, 3'd4);
    sendFrame(8, 8'h81, 1'b1, 1'b1);
    chk("R2 nine-bit frame", 16'({rxReady, rxType, rxData}), 16'h381);
    readReg();
  endtask

  task automatic testGlitch();
    rxLine = 1'b0; idle(6);
    rxLine = 1'b1; idle(4 * BITCLK);
    chk("R3 glitch ignored", 16'({rxReady, rxData}), 16'h081);
    sendFrame(8, 8'h6E, 1'b0, 1'b1);
    chk("R3 frame after glitch", 16'({rxReady, rxData}), 16'h16E);
    readReg();
  endtask

  task automatic testMpFilter();
    writeCfg(1'b1, 3'd4);
    chk("R10 mpMode load", 16'(mpMode), 16'h1);
    sendFrame(8, 8'h55, 1'b0, 1'b1);
    chk("R4 data frame dropped", 16'({rxReady, rxOverrun, rxType, rxData}), 16'h006E);
    sendFrame(8, 8'h12, 1'b1, 1'b1);
    chk("R5 address delivered", 16'({rxReady, rxType, rxData}), 16'h312);
    readReg();
  endtask

  task automatic testTxDone();
    txDoneSet = 1'b1; idle(1); txDoneSet = 1'b0; idle(1);
    chk("R10 txDone set", 16'(txDone), 16'h1);
    writeCfg(1'b0, 3'd3);
    chk("R10 cfg keeps txDone", 16'({mpMode, txDone}), 16'h1);
    txDoneClr = 1'b1; idle(1); txDoneClr = 1'b0; idle(1);
    chk("R10 txDone cleared", 16'(txDone), 16'h0);
  endtask

  task automatic testFrameErr();
    sendFrame(8, 8'hC3, 1'b0, 1'b0);
    chk("R7 frame error stored", 16'({rxReady, rxFrameErr, rxData}), 16'h3C3);
    readReg();
    sendFrame(8, 8'h0F, 1'b0, 1'b1);
    chk("R7 error cleared by good frame", 16'(rxFrameErr), 16'h0);
    readReg();
  endtask

  task automatic testOverrun();
    sendFrame(8, 8'h11, 1'b0, 1'b1);
    sendFrame(8, 8'h22, 1'b1, 1'b1);
    chk("R8 overrun set", 16'({rxReady, rxOverrun}), 16'h3);
    chk("R8 old frame kept", 16'({rxType, rxData}), 16'h011);
    readReg();
    chk("R9 read clears overrun", 16'({rxReady, rxOverrun}), 16'h0);
  endtask

  initial begin
    idle(4);
    testReset();
    rstN = 1'b1;
    idle(4);
    testReset();
    testPlainFrames();
    testSizes();
    testGlitch();
    testMpFilter();
    testTxDone();
    testFrameErr();
    testOverrun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule